// File: doc/BRIEF.md
# Split Hold/Status Interrupt Controller

This block gathers interrupt requests from fourteen sources and turns them into two processor request lines, a normal interrupt (IRQ) and a fast interrupt (FIQ). Each source drives a one-bit set request and a one-bit clear request. Sources in a fixed group (bits 0 to 4 and bit 9, the five buttons and the real-time clock) are tracked in a live status register. Every other source is latched in a hold register, and only the hold register can raise a processor line.

Software reaches the block through a small 32-bit register window at byte offsets 0x00 to 0x10. The enable register cannot be written directly. One offset turns enable bits on, and another offset turns them off. A third offset acknowledges pending requests by clearing the selected bits in both hold and status. Two fixed route masks decide which enabled hold bits drive IRQ and which drive FIQ. Both outputs come from flops, so they follow the register state with one cycle of delay.

Top module: `intc_split_ctrl`

## Requirements
- R1: After a synchronous active-low reset, hold, status and enable are all zero, irq and fiq are low, and every read returns zero.
- R2: A set request on a source in the status group (mask 0x021F: bits 0-4 and 9) sets that bit of status. Status reads at offset 0x04 on the next cycle. The set request leaves hold unchanged.
- R3: A set request on any other source (mask 0x3DE0) sets that bit of hold. Hold reads at offset 0x00 on the next cycle. Hold bits in the status group are always zero.
- R4: A clear request from a source clears that bit in both hold and status. If set and clear arrive in the same cycle, set wins.
- R5: A write to offset 0x08 ORs data bits 13:0 into enable. A read of offset 0x08 returns enable.
- R6: A write to offset 0x0C clears the written bits in enable. A read of offset 0x0C returns zero.
- R7: A write to offset 0x10 clears the written bits in both hold and status. A set request on the same bit in the same cycle wins. A read of offset 0x10 returns zero.
- R8: Writes to offsets 0x00 and 0x04, and to any offset not listed, change nothing. Reads of offsets not listed return zero.
- R9: irq is high exactly one cycle after hold & enable & 0x1FBF is non-zero.
- R10: fiq is high exactly one cycle after hold & enable & 0x2040 is non-zero. Bit 6 and bit 13 route to fiq.
- R11: Write data bits 31:14 have no effect, and read data bits 31:14 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_set | input | 14 | Per-source set request, one bit per source |
| src_clr | input | 14 | Per-source clear request, one bit per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en, zero otherwise |
| irq | output | 1 | Registered normal interrupt request |
| fiq | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume a word-aligned byte offset and at most one register access per cycle, so that a write strobe never shares a cycle with a read strobe. The stimulus keeps within these limits by drawing addresses only as multiples of four in the range 0x00 to 0x1C, which also covers unmapped offsets, and by choosing a single access kind in each cycle. Source requests are sparse random vectors. Set and clear requests may collide with each other and with an acknowledge on the same bit. These collisions are exactly the cases the set-wins rules cover.

// File: rtl/intc_pkg.sv
// Shared constants for the split hold/status interrupt controller.
// Assumes fourteen sources. The route masks are fixed properties of the block.
package intc_pkg;

    localparam int unsigned INTC_SRC_N = 14;

    // Sources tracked as live status rather than latched in hold.
    localparam logic [INTC_SRC_N-1:0] INTC_STATUS_GRP = 14'h021F;
    // Enabled hold bits that drive the normal request line.
    localparam logic [INTC_SRC_N-1:0] INTC_IRQ_ROUTE  = 14'h1FBF;
    // Enabled hold bits that drive the fast request line.
    localparam logic [INTC_SRC_N-1:0] INTC_FIQ_ROUTE  = 14'h2040;

    // Byte offsets of the register window.
    typedef enum logic [7:0] {
        REG_HOLD   = 8'h00,
        REG_STATUS = 8'h04,
        REG_EN_SET = 8'h08,
        REG_EN_CLR = 8'h0C,
        REG_ACK    = 8'h10
    } intc_reg_e;

endpackage

// File: rtl/intc_src_track.sv
// Per-source request tracking. Each bit is built either as a status flop or as
// a hold flop, as the group mask chooses. Set requests win over source clears
// and over software acknowledges in the same cycle.
module intc_src_track #(
    parameter int unsigned           NUM_SRC    = 14,
    parameter logic [NUM_SRC-1:0]    STATUS_GRP = 14'h021F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic [NUM_SRC-1:0] ack_bits,
    output logic [NUM_SRC-1:0] hold_q,
    output logic [NUM_SRC-1:0] status_q
);

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_bit
        if (STATUS_GRP[gi]) begin : g_status
            // Live status bit: set by source, cleared by source clear or acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q[gi] <= 1'b0;
                else if (src_set[gi])
                    status_q[gi] <= 1'b1;
                else if (src_clr[gi] || ack_bits[gi])
                    status_q[gi] <= 1'b0;
            end
            assign hold_q[gi] = 1'b0;
        end else begin : g_hold
            // Latched hold bit: set by source, cleared by source clear or acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hold_q[gi] <= 1'b0;
                else if (src_set[gi])
                    hold_q[gi] <= 1'b1;
                else if (src_clr[gi] || ack_bits[gi])
                    hold_q[gi] <= 1'b0;
            end
            assign status_q[gi] = 1'b0;
        end
    end

endmodule

// File: rtl/intc_enable_reg.sv
// Enable register with separate set and clear paths and no direct load.
// Assumes set and clear strobes never come in the same cycle.
// The bus decoder guarantees this, because it handles one write per cycle.
module intc_enable_reg #(
    parameter int unsigned NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] en_set_bits,
    input  logic [NUM_SRC-1:0] en_clr_bits,
    output logic [NUM_SRC-1:0] enable_q
);

    // Apply the bitwise OR and the bitwise clear to the enable state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else
            enable_q <= (enable_q | en_set_bits) & ~en_clr_bits;
    end

endmodule

// File: rtl/intc_bus_decode.sv
// Register window decode. Turns one write into set, clear or acknowledge
// vectors and returns read data combinationally while rd_en is high.
// Assumes word-aligned byte offsets. Only data bits below NUM_SRC are used.
module intc_bus_decode
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 14,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] hold_q,
    input  logic [NUM_SRC-1:0] status_q,
    input  logic [NUM_SRC-1:0] enable_q,
    output logic [NUM_SRC-1:0] en_set_bits,
    output logic [NUM_SRC-1:0] en_clr_bits,
    output logic [NUM_SRC-1:0] ack_bits,
    output logic [DATA_W-1:0]  rdata
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] rsel;
    logic               unused_hi;

    assign wbits     = wdata[NUM_SRC-1:0];
    assign unused_hi = ^wdata[DATA_W-1:NUM_SRC];

    // Route a write to the set-enable, clear-enable or acknowledge vector.
    always_comb begin
        en_set_bits = '0;
        en_clr_bits = '0;
        ack_bits    = '0;
        if (wr_en) begin
            if (addr == ADDR_W'(REG_EN_SET)) en_set_bits = wbits;
            if (addr == ADDR_W'(REG_EN_CLR)) en_clr_bits = wbits;
            if (addr == ADDR_W'(REG_ACK))    ack_bits    = wbits;
        end
    end

    // Select read data. Write-only and unmapped offsets read as zero.
    always_comb begin
        rsel = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(REG_HOLD))   rsel = hold_q;
            if (addr == ADDR_W'(REG_STATUS)) rsel = status_q;
            if (addr == ADDR_W'(REG_EN_SET)) rsel = enable_q;
        end
    end

    assign rdata = {{PAD_W{1'b0}}, rsel};

endmodule

// File: rtl/intc_out_stage.sv
// Output stage: masks enabled hold bits through the two route masks and
// registers the result, so each line lags the state by one cycle.
module intc_out_stage #(
    parameter int unsigned        NUM_SRC   = 14,
    parameter logic [NUM_SRC-1:0] IRQ_ROUTE = 14'h1FBF,
    parameter logic [NUM_SRC-1:0] FIQ_ROUTE = 14'h2040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hold_q,
    input  logic [NUM_SRC-1:0] enable_q,
    output logic               irq,
    output logic               fiq
);

    logic [NUM_SRC-1:0] live;

    assign live = hold_q & enable_q;

    // Register both request lines from the routed pending vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            fiq <= 1'b0;
        end else begin
            irq <= |(live & IRQ_ROUTE);
            fiq <= |(live & FIQ_ROUTE);
        end
    end

endmodule

// File: rtl/intc_split_ctrl.sv
// Top of the split hold/status interrupt controller. It joins source
// tracking, the set/clear enable register, the register window decode and
// the registered output stage. Assumes one register access per cycle.
module intc_split_ctrl
    import intc_pkg::*;
#(
    parameter int unsigned        NUM_SRC    = INTC_SRC_N,
    parameter int unsigned        ADDR_W     = 8,
    parameter int unsigned        DATA_W     = 32,
    parameter logic [NUM_SRC-1:0] STATUS_GRP = INTC_STATUS_GRP,
    parameter logic [NUM_SRC-1:0] IRQ_ROUTE  = INTC_IRQ_ROUTE,
    parameter logic [NUM_SRC-1:0] FIQ_ROUTE  = INTC_FIQ_ROUTE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_SRC-1:0] src_clr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq,
    output logic               fiq
);

    logic [NUM_SRC-1:0] hold_q;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] en_set_bits;
    logic [NUM_SRC-1:0] en_clr_bits;
    logic [NUM_SRC-1:0] ack_bits;

    intc_bus_decode #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_decode (
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .hold_q      (hold_q),
        .status_q    (status_q),
        .enable_q    (enable_q),
        .en_set_bits (en_set_bits),
        .en_clr_bits (en_clr_bits),
        .ack_bits    (ack_bits),
        .rdata       (rdata)
    );

    intc_src_track #(
        .NUM_SRC(NUM_SRC), .STATUS_GRP(STATUS_GRP)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_set  (src_set),
        .src_clr  (src_clr),
        .ack_bits (ack_bits),
        .hold_q   (hold_q),
        .status_q (status_q)
    );

    intc_enable_reg #(
        .NUM_SRC(NUM_SRC)
    ) u_enable (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_set_bits (en_set_bits),
        .en_clr_bits (en_clr_bits),
        .enable_q    (enable_q)
    );

    intc_out_stage #(
        .NUM_SRC(NUM_SRC), .IRQ_ROUTE(IRQ_ROUTE), .FIQ_ROUTE(FIQ_ROUTE)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_q   (hold_q),
        .enable_q (enable_q),
        .irq      (irq),
        .fiq      (fiq)
    );

endmodule

// File: rtl/intc_split_ctrl_chk.sv
// Checker for the split hold/status interrupt controller. It watches the
// top-level ports and the three state vectors, and a bind statement attaches it.
// Assumes word-aligned offsets and one access per cycle.
module intc_split_ctrl_chk #(
    parameter int unsigned        NUM_SRC    = 14,
    parameter int unsigned        ADDR_W     = 8,
    parameter int unsigned        DATA_W     = 32,
    parameter logic [NUM_SRC-1:0] STATUS_GRP = 14'h021F,
    parameter logic [NUM_SRC-1:0] IRQ_ROUTE  = 14'h1FBF,
    parameter logic [NUM_SRC-1:0] FIQ_ROUTE  = 14'h2040
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_set,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [NUM_SRC-1:0] hold_q,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic               irq,
    input logic               fiq
);

    logic primed;

    // Mark that at least one clock edge out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    p_status_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_set & STATUS_GRP)) |=>
            ((status_q & $past(src_set & STATUS_GRP)) == $past(src_set & STATUS_GRP)));

    p_hold_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_set & ~STATUS_GRP)) |=>
            ((hold_q & $past(src_set & ~STATUS_GRP)) == $past(src_set & ~STATUS_GRP)));

    p_hold_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q & STATUS_GRP) == '0);

    p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h08)) |=>
            ((enable_q & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0])));

    p_en_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h0C)) |=>
            ((enable_q & $past(wdata[NUM_SRC-1:0])) == '0));

    p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(8'h10)) |=>
            (((hold_q | status_q) & $past(wdata[NUM_SRC-1:0] & ~src_set)) == '0));

    p_ro_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(8'h00) || addr == ADDR_W'(8'h04))) |=>
            $stable(enable_q));

    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> (irq == $past(|(hold_q & enable_q & IRQ_ROUTE))));

    p_fiq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> (fiq == $past(|(hold_q & enable_q & FIQ_ROUTE))));

endmodule

bind intc_split_ctrl intc_split_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_GRP(STATUS_GRP), .IRQ_ROUTE(IRQ_ROUTE), .FIQ_ROUTE(FIQ_ROUTE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_set  (src_set),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .hold_q   (hold_q),
    .status_q (status_q),
    .enable_q (enable_q),
    .irq      (irq),
    .fiq      (fiq)
);

// File: tb/test_intc_split_ctrl.sv
// Self-checking bench: directed corner cases followed by seeded random traffic.
// A bench-side model computes the expected values.
module test_intc_split_ctrl;

    localparam int unsigned N    = 14;
    localparam logic [13:0] STAT = 14'h021F;
    localparam logic [13:0] IRQM = 14'h1FBF;
    localparam logic [13:0] FIQM = 14'h2040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src_set = '0;
    logic [13:0] src_clr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        fiq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [13:0] m_hold = '0, m_stat = '0, m_en = '0;
    logic        m_irq = 1'b0, m_fiq = 1'b0;

    always #2.5 clk = ~clk;

    intc_split_ctrl i_intc_split_ctrl (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .fiq(fiq)
    );

    // Expected read value from the bench model.
    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return {18'd0, m_hold};
            8'h04:   return {18'd0, m_stat};
            8'h08:   return {18'd0, m_en};
            default: return 32'd0;
        endcase
    endfunction

    // Requirement that a read at this offset exercises.
    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h00:   return "R3";
            8'h04:   return "R2";
            8'h08:   return "R5";
            8'h0C:   return "R6";
            8'h10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check outputs, then update the model.
    task automatic step(input logic [13:0] s, input logic [13:0] c, input logic we,
                        input logic re, input logic [7:0] a, input logic [31:0] d);
        logic [13:0] ack, es, ec;
        @(negedge clk);
        src_set = s; src_clr = c; wr_en = we; rd_en = re; addr = a; wdata = d;
        #1;
        if (re) check(read_tag(a), rdata, model_read(a));
        else    check("R8", rdata, 32'd0);
        check("R9", {31'd0, irq}, {31'd0, m_irq});
        check("R10", {31'd0, fiq}, {31'd0, m_fiq});
        ack = (we && a == 8'h10) ? d[13:0] : 14'd0;
        es  = (we && a == 8'h08) ? d[13:0] : 14'd0;
        ec  = (we && a == 8'h0C) ? d[13:0] : 14'd0;
        m_irq  = |(m_hold & m_en & IRQM);
        m_fiq  = |(m_hold & m_en & FIQM);
        m_stat = ((m_stat & ~ack & ~c) | s) & STAT;
        m_hold = ((m_hold & ~ack & ~c) | s) & ~STAT;
        m_en   = (m_en | es) & ~ec;
    endtask

    task automatic rd(input logic [7:0] a);
        step('0, '0, 1'b0, 1'b1, a, '0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step('0, '0, 1'b1, 1'b0, a, d);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: everything reads zero after reset.
        rd(8'h00); rd(8'h04); rd(8'h08);
        check("R1", {30'd0, irq, fiq}, 32'd0);

        // R2 / R3: a status-group set and a hold-group set.
        step(14'h0201, '0, 1'b0, 1'b0, 8'h00, '0);
        rd(8'h04); rd(8'h00);
        step(14'h2080, '0, 1'b0, 1'b0, 8'h00, '0);
        rd(8'h00); rd(8'h04);

        // R5, R9, R10: enable timer bits. The lines rise one cycle after the write.
        wr(8'h08, 32'h0000_2080);
        rd(8'h08); rd(8'h08);
        check("R9", {31'd0, irq}, 32'd1);
        check("R10", {31'd0, fiq}, 32'd1);

        // R8: writes to hold, status and an unmapped offset have no effect.
        wr(8'h00, 32'h0000_3FFF); wr(8'h04, 32'h0000_0000); wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h14);

        // R7: an acknowledge collides with a set on bit 7. Set wins, and bit 13 clears.
        step(14'h0080, '0, 1'b1, 1'b0, 8'h10, 32'h0000_2080);
        rd(8'h00); rd(8'h10);

        // R4: a clear alongside a set keeps the bit. A clear alone drops it.
        step(14'h0001, 14'h0081, 1'b0, 1'b0, 8'h00, '0);
        rd(8'h00); rd(8'h04);
        step('0, 14'h0081, 1'b0, 1'b0, 8'h00, '0);
        rd(8'h00); rd(8'h04);

        // R6: clear-enable of bit 13 drops fiq. The offset reads zero.
        step(14'h2000, '0, 1'b0, 1'b0, 8'h00, '0);
        rd(8'h00); rd(8'h00);
        wr(8'h0C, 32'h0000_2000);
        rd(8'h0C); rd(8'h08);
        check("R6", {31'd0, fiq}, 32'd0);

        // R11: data bits above 13 are ignored on writes and read as zero.
        wr(8'h08, 32'hFFFF_C000);
        rd(8'h08);
        check("R11", rdata, {18'd0, m_en});

        // Seeded random traffic.
        for (int k = 0; k < 4000; k++) begin
            logic [13:0] s, c;
            logic [2:0] kind;
            s    = 14'($urandom & $urandom & $urandom);
            c    = 14'($urandom & $urandom & $urandom);
            kind = 3'($urandom_range(0, 5));
            if (kind < 2)
                step(s, c, 1'b1, 1'b0, {3'($urandom_range(0, 7)), 2'b00},
                     (kind == 0) ? $urandom : ($urandom & $urandom));
            else if (kind < 5)
                step(s, c, 1'b0, 1'b1, {3'($urandom_range(0, 7)), 2'b00}, '0);
            else
                step(s, c, 1'b0, 1'b0, 8'h00, '0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule